// File: doc/BRIEF.md
# Two-Thread Shared Reorder Buffer

This block keeps the program order of in-flight micro-ops between the rename stage and retirement in an out-of-order core that runs two hardware threads. A single circular store of 128 entries holds the micro-ops of both threads, interleaved in the order they arrive. Each entry records whether it is live, whether it has finished executing, which thread owns it, and a 7-bit micro-op tag. Up to four micro-ops are accepted per cycle. Each one is placed in the next free slot, and the slot number is handed back so that execution units can report completion by index.

Retirement looks at the four oldest slots each cycle. An entry leaves when it has completed and every older entry of the same thread has either left or been squashed. Each retiring entry is reported with its thread, tag and slot, so the result goes back to the thread that issued it. A stalled entry of one thread does not hold back finished entries of the other thread in that window.

A mispredicted branch of one thread squashes all of that thread's entries that are younger than the branch. The squashed slots become holes, and the oldest-slot pointer steps over them later.

Top module: `rob_dual_thread`

## Requirements
- R1: After reset the buffer is empty: `alloc_base` is 0, `alloc_ready` is high for any request of 1 to 4, and no retirement lane is valid.
- R2: When `alloc_cnt` = n (1..4) and `alloc_ready` is high at a clock edge, lane k (k < n) takes slot (`alloc_base` + k) mod 128, and `alloc_base` then advances by n.
- R3: `alloc_ready` is low when fewer than `alloc_cnt` slots are free, and then nothing is allocated and `alloc_base` holds.
- R4: A pulse on `wb_valid[p]` marks the entry at slot `wb_idx[p]` as completed from the next cycle on. Several ports may complete different entries in the same cycle.
- R5: Retirement lane k always refers to the slot k places after the oldest occupied slot, and reports its slot in `ret_idx[k]`, its thread in `ret_thr[k]` and its tag in `ret_tag[k]`. At most four entries retire per cycle.
- R6: An entry retires only when it has completed and no older live entry of the same thread is still waiting. Each thread's entries therefore retire in allocation order, even when they complete out of order.
- R7: A waiting entry of one thread does not stop completed entries of the other thread within the four-slot window from retiring.
- R8: `flush_valid` with thread t and slot b removes every live thread-t entry that is younger than b, and none of those entries ever retires. Entry b, older entries and entries of the other thread are unaffected.
- R9: Slots that have retired or been squashed become free once the oldest-slot pointer passes them, so that all 128 slots can be refilled after a full buffer drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_cnt | input | 3 | Number of micro-ops offered this cycle (0..4), filled from lane 0 up |
| alloc_thr | input | 4 | Thread of each allocation lane |
| alloc_tag | input | 4x7 | Micro-op tag of each allocation lane |
| alloc_ready | output | 1 | Enough free slots for the offered count |
| alloc_base | output | 7 | Slot taken by allocation lane 0 |
| wb_valid | input | 3 | Completion strobe per writeback port |
| wb_idx | input | 3x7 | Completed slot per writeback port |
| flush_valid | input | 1 | Squash request from branch resolution |
| flush_thr | input | 1 | Thread of the mispredicted branch |
| flush_idx | input | 7 | Slot of the mispredicted branch |
| ret_valid | output | 4 | Retirement lane fires this cycle |
| ret_thr | output | 4 | Thread of each retirement lane |
| ret_tag | output | 4x7 | Tag of each retirement lane |
| ret_idx | output | 7x4 | Slot of each retirement lane (4 lanes of 7 bits) |

## Verification
The properties assume the following about the inputs. `alloc_cnt` never exceeds four. Every writeback names a live slot that has not yet completed, and no slot is named twice. A flush names a live, not-yet-completed slot of the thread it squashes. The bench keeps to these assumptions in three ways. It draws writeback targets only from its own list of outstanding slots and removes each one as it is used. It takes the flush branch as the oldest outstanding entry of the chosen thread. It issues each random flush in a cycle that carries no allocation and no writeback.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int ROB_DEPTH   = 128;
  localparam int ALLOC_LANES = 4;
  localparam int RET_LANES   = 4;
  localparam int WB_PORTS    = 3;
  localparam int UOP_TAG_W   = 7;
endpackage

// File: rtl/rob_alloc_ctrl.sv
module rob_alloc_ctrl #(
  parameter int DEPTH   = rob_pkg::ROB_DEPTH,
  parameter int ALLOC_W = rob_pkg::ALLOC_LANES,
  parameter int RET_W   = rob_pkg::RET_LANES,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ACNT_W = $clog2(ALLOC_W + 1),
  localparam int RCNT_W = $clog2(RET_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ACNT_W-1:0] alloc_cnt,
  input  logic [RCNT_W-1:0] ret_adv,
  output logic              alloc_ready,
  output logic              alloc_fire,
  output logic [IDX_W-1:0]  head_q,
  output logic [IDX_W-1:0]  tail_q,
  output logic [CNT_W-1:0]  count_q
);
  logic [CNT_W-1:0] free_slots;
  logic [CNT_W-1:0] take;
  logic [IDX_W-1:0] head_n, tail_n;
  logic [CNT_W-1:0] count_n;
  logic             ptr_en;

  // next-state
  always_comb begin
    free_slots  = CNT_W'(DEPTH) - count_q;
    alloc_ready = (alloc_cnt <= ACNT_W'(ALLOC_W)) && (CNT_W'(alloc_cnt) <= free_slots);
    alloc_fire  = alloc_ready && (alloc_cnt != '0);
    take        = alloc_fire ? CNT_W'(alloc_cnt) : '0;
    head_n      = head_q + IDX_W'(ret_adv);
    tail_n      = tail_q + IDX_W'(take);
    count_n     = count_q - CNT_W'(ret_adv) + take;
    ptr_en      = alloc_fire || (ret_adv != '0);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (ptr_en) begin
      head_q  <= head_n;
      tail_q  <= tail_n;
      count_q <= count_n;
    end
  end
endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel #(
  parameter int DEPTH  = rob_pkg::ROB_DEPTH,
  parameter int RET_W  = rob_pkg::RET_LANES,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int RCNT_W = $clog2(RET_W + 1)
) (
  input  logic [IDX_W-1:0]            head_q,
  input  logic [CNT_W-1:0]            count_q,
  input  logic [DEPTH-1:0]            valid_q,
  input  logic [DEPTH-1:0]            done_q,
  input  logic [DEPTH-1:0]            thr_q,
  output logic [RET_W-1:0]            ret_fire,
  output logic [RET_W-1:0][IDX_W-1:0] ret_slot,
  output logic [RCNT_W-1:0]           ret_adv
);
  logic [1:0]       blocked;
  logic             stop;
  logic             occ;
  logic [IDX_W-1:0] slot;

  // Scan the oldest slots: a waiting live entry blocks younger entries of its thread,
  // and the head moves over the unbroken run of holes and retiring entries.
  always_comb begin
    blocked = '0;
    stop    = 1'b0;
    ret_adv = '0;
    occ     = 1'b0;
    slot    = '0;
    for (int k = 0; k < RET_W; k++) begin
      slot        = head_q + IDX_W'(k);
      ret_slot[k] = slot;
      occ         = CNT_W'(k) < count_q;
      ret_fire[k] = occ && valid_q[slot] && done_q[slot] && !blocked[thr_q[slot]];
      if (occ && valid_q[slot] && !ret_fire[k]) blocked[thr_q[slot]] = 1'b1;
      if (!stop && occ && (!valid_q[slot] || ret_fire[k])) ret_adv = ret_adv + RCNT_W'(1);
      else stop = 1'b1;
    end
  end
endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array #(
  parameter int DEPTH   = rob_pkg::ROB_DEPTH,
  parameter int ALLOC_W = rob_pkg::ALLOC_LANES,
  parameter int RET_W   = rob_pkg::RET_LANES,
  parameter int WB_N    = rob_pkg::WB_PORTS,
  parameter int TAG_W   = rob_pkg::UOP_TAG_W,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int ACNT_W  = $clog2(ALLOC_W + 1),
  localparam int LANE_W  = (ALLOC_W > 1) ? $clog2(ALLOC_W) : 1,
  localparam int RLANE_W = (RET_W > 1) ? $clog2(RET_W) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [IDX_W-1:0]               head_q,
  input  logic [IDX_W-1:0]               tail_q,
  input  logic [CNT_W-1:0]               count_q,
  input  logic                           alloc_fire,
  input  logic [ACNT_W-1:0]              alloc_cnt,
  input  logic [ALLOC_W-1:0]             alloc_thr,
  input  logic [ALLOC_W-1:0][TAG_W-1:0]  alloc_tag,
  input  logic [WB_N-1:0]                wb_valid,
  input  logic [WB_N-1:0][IDX_W-1:0]     wb_idx,
  input  logic                           flush_valid,
  input  logic                           flush_thr,
  input  logic [IDX_W-1:0]               flush_idx,
  input  logic [RET_W-1:0]               ret_fire,
  output logic [DEPTH-1:0]               valid_q,
  output logic [DEPTH-1:0]               done_q,
  output logic [DEPTH-1:0]               thr_q,
  output logic [DEPTH-1:0][TAG_W-1:0]    tag_q
);
  logic [IDX_W-1:0] branch_age;
  assign branch_age = flush_idx - head_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [IDX_W-1:0] aoff, hoff;
    logic             ahit, rhit, kill, whit;
    logic             val_n, done_n, state_en;
    logic             val_r, done_r, thr_r;
    logic [TAG_W-1:0] tag_r;

    always_comb begin
      aoff = IDX_W'(i) - tail_q;
      hoff = IDX_W'(i) - head_q;
      ahit = alloc_fire && (aoff < IDX_W'(alloc_cnt));
      rhit = (hoff < IDX_W'(RET_W)) && ret_fire[hoff[RLANE_W-1:0]];
      kill = flush_valid && val_r && (thr_r == flush_thr) &&
             (CNT_W'(hoff) < count_q) && (hoff > branch_age);
      whit = 1'b0;
      for (int p = 0; p < WB_N; p++)
        if (wb_valid[p] && (wb_idx[p] == IDX_W'(i))) whit = 1'b1;
      val_n  = val_r;
      done_n = done_r;
      if (rhit || kill) val_n = 1'b0;
      if (whit) done_n = 1'b1;
      if (ahit) begin
        val_n  = 1'b1;
        done_n = 1'b0;
      end
      state_en = (val_n != val_r) || (done_n != done_r);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_r  <= 1'b0;
        done_r <= 1'b0;
      end else if (state_en) begin
        val_r  <= val_n;
        done_r <= done_n;
      end
    end

    always_ff @(posedge clk) begin
      if (ahit) begin
        thr_r <= alloc_thr[aoff[LANE_W-1:0]];
        tag_r <= alloc_tag[aoff[LANE_W-1:0]];
      end
    end

    assign valid_q[i] = val_r;
    assign done_q[i]  = done_r;
    assign thr_q[i]   = thr_r;
    assign tag_q[i]   = tag_r;
  end
endmodule

// File: rtl/rob_dual_thread.sv
module rob_dual_thread #(
  parameter int DEPTH   = rob_pkg::ROB_DEPTH,
  parameter int ALLOC_W = rob_pkg::ALLOC_LANES,
  parameter int RET_W   = rob_pkg::RET_LANES,
  parameter int WB_N    = rob_pkg::WB_PORTS,
  parameter int TAG_W   = rob_pkg::UOP_TAG_W,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ACNT_W = $clog2(ALLOC_W + 1),
  localparam int RCNT_W = $clog2(RET_W + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ACNT_W-1:0]             alloc_cnt,
  input  logic [ALLOC_W-1:0]            alloc_thr,
  input  logic [ALLOC_W-1:0][TAG_W-1:0] alloc_tag,
  output logic                          alloc_ready,
  output logic [IDX_W-1:0]              alloc_base,
  input  logic [WB_N-1:0]               wb_valid,
  input  logic [WB_N-1:0][IDX_W-1:0]    wb_idx,
  input  logic                          flush_valid,
  input  logic                          flush_thr,
  input  logic [IDX_W-1:0]              flush_idx,
  output logic [RET_W-1:0]              ret_valid,
  output logic [RET_W-1:0]              ret_thr,
  output logic [RET_W-1:0][TAG_W-1:0]   ret_tag,
  output logic [RET_W-1:0][IDX_W-1:0]   ret_idx
);
  logic                       alloc_fire;
  logic [IDX_W-1:0]           head_q, tail_q;
  logic [CNT_W-1:0]           count_q;
  logic [RCNT_W-1:0]          ret_adv;
  logic [RET_W-1:0]           ret_fire;
  logic [RET_W-1:0][IDX_W-1:0] ret_slot;
  logic [DEPTH-1:0]           valid_q, done_q, thr_q;
  logic [DEPTH-1:0][TAG_W-1:0] tag_q;

  rob_alloc_ctrl #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .RET_W(RET_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .alloc_cnt(alloc_cnt), .ret_adv(ret_adv),
    .alloc_ready(alloc_ready), .alloc_fire(alloc_fire),
    .head_q(head_q), .tail_q(tail_q), .count_q(count_q)
  );

  rob_retire_sel #(.DEPTH(DEPTH), .RET_W(RET_W)) u_sel (
    .head_q(head_q), .count_q(count_q), .valid_q(valid_q), .done_q(done_q),
    .thr_q(thr_q), .ret_fire(ret_fire), .ret_slot(ret_slot), .ret_adv(ret_adv)
  );

  rob_entry_array #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .RET_W(RET_W),
                    .WB_N(WB_N), .TAG_W(TAG_W)) u_array (
    .clk(clk), .rst_n(rst_n), .head_q(head_q), .tail_q(tail_q), .count_q(count_q),
    .alloc_fire(alloc_fire), .alloc_cnt(alloc_cnt), .alloc_thr(alloc_thr),
    .alloc_tag(alloc_tag), .wb_valid(wb_valid), .wb_idx(wb_idx),
    .flush_valid(flush_valid), .flush_thr(flush_thr), .flush_idx(flush_idx),
    .ret_fire(ret_fire), .valid_q(valid_q), .done_q(done_q), .thr_q(thr_q), .tag_q(tag_q)
  );

  assign alloc_base = tail_q;
  assign ret_valid  = ret_fire;
  assign ret_idx    = ret_slot;

  for (genvar k = 0; k < RET_W; k++) begin : g_ret
    assign ret_thr[k] = thr_q[ret_slot[k]];
    assign ret_tag[k] = tag_q[ret_slot[k]];
  end
endmodule

// File: rtl/rob_dual_thread_chk.sv
module rob_dual_thread_chk #(
  parameter int DEPTH   = 128,
  parameter int ALLOC_W = 4,
  parameter int RET_W   = 4,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ACNT_W = $clog2(ALLOC_W + 1)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ACNT_W-1:0]           alloc_cnt,
  input logic                        alloc_ready,
  input logic [IDX_W-1:0]            alloc_base,
  input logic                        flush_valid,
  input logic [IDX_W-1:0]            flush_idx,
  input logic [RET_W-1:0]            ret_valid,
  input logic [RET_W-1:0]            ret_thr,
  input logic [RET_W-1:0][IDX_W-1:0] ret_idx,
  input logic [CNT_W-1:0]            count_q,
  input logic [DEPTH-1:0]            valid_q,
  input logic [DEPTH-1:0]            done_q,
  input logic [DEPTH-1:0]            thr_q
);
  // R2
  base_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_ready && alloc_cnt != '0) |=> alloc_base == $past(alloc_base) + IDX_W'($past(alloc_cnt)));

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_ready || alloc_cnt == '0) |=> $stable(alloc_base));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  // R8
  flush_keeps_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> valid_q[$past(flush_idx)]);

  for (genvar k = 0; k < RET_W; k++) begin : g_lane
    // R4
    done_before_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid[k] |-> (valid_q[ret_idx[k]] && done_q[ret_idx[k]]));
    for (genvar j = 0; j < k; j++) begin : g_older
      // R6
      in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid[k] && valid_q[ret_idx[j]] && (thr_q[ret_idx[j]] == ret_thr[k]))
          |-> ret_valid[j]);
    end
  end
endmodule

bind rob_dual_thread rob_dual_thread_chk #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .RET_W(RET_W)) u_rob_chk (
  .clk(clk), .rst_n(rst_n), .alloc_cnt(alloc_cnt), .alloc_ready(alloc_ready),
  .alloc_base(alloc_base), .flush_valid(flush_valid), .flush_idx(flush_idx),
  .ret_valid(ret_valid), .ret_thr(ret_thr), .ret_idx(ret_idx),
  .count_q(count_q), .valid_q(valid_q), .done_q(done_q), .thr_q(thr_q)
);

// File: tb/test_rob_dual_thread.sv
`timescale 1ns/1ps
module test_rob_dual_thread;
  localparam int DEPTH = 128, AW = 4, RW = 4, WBN = 3, TW = 7;
  localparam int IW = $clog2(DEPTH), ACW = $clog2(AW + 1);

  logic clk, rst_n;
  logic [ACW-1:0]         alloc_cnt;
  logic [AW-1:0]          alloc_thr;
  logic [AW-1:0][TW-1:0]  alloc_tag;
  logic                   alloc_ready;
  logic [IW-1:0]          alloc_base;
  logic [WBN-1:0]         wb_valid;
  logic [WBN-1:0][IW-1:0] wb_idx;
  logic                   flush_valid, flush_thr;
  logic [IW-1:0]          flush_idx;
  logic [RW-1:0]          ret_valid, ret_thr;
  logic [RW-1:0][TW-1:0]  ret_tag;
  logic [RW-1:0][IW-1:0]  ret_idx;

  rob_dual_thread i_rob_dual_thread (
    .clk(clk), .rst_n(rst_n), .alloc_cnt(alloc_cnt), .alloc_thr(alloc_thr),
    .alloc_tag(alloc_tag), .alloc_ready(alloc_ready), .alloc_base(alloc_base),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .flush_valid(flush_valid),
    .flush_thr(flush_thr), .flush_idx(flush_idx), .ret_valid(ret_valid),
    .ret_thr(ret_thr), .ret_tag(ret_tag), .ret_idx(ret_idx)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct { int idx; int thr; int tag; int seq; } item_t;
  item_t q0[$];
  item_t q1[$];
  item_t pend[$];
  int checks = 0, fails = 0, seqn = 0;
  int tagc[2] = '{0, 0};

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Scoreboard monitor: each retirement must match the oldest outstanding entry of its thread
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1) begin
        for (int k = 0; k < RW; k++) begin
          if (ret_valid[k]) begin
            item_t e;
            bit have;
            have = 1'b0;
            if (ret_thr[k] == 1'b0 && q0.size() > 0) begin e = q0.pop_front(); have = 1'b1; end
            else if (ret_thr[k] == 1'b1 && q1.size() > 0) begin e = q1.pop_front(); have = 1'b1; end
            if (!have) check(1'b0, "R8 retirement with nothing outstanding", int'(ret_idx[k]), -1);
            else begin
              check(int'(ret_tag[k]) == e.tag, "R6 per-thread retire order (tag)", int'(ret_tag[k]), e.tag);
              check(int'(ret_idx[k]) == e.idx, "R5 retire lane slot", int'(ret_idx[k]), e.idx);
            end
          end
        end
      end
    end
  end

  task automatic clear_inputs();
    alloc_cnt = '0; alloc_thr = '0; alloc_tag = '0;
    wb_valid = '0; wb_idx = '0;
    flush_valid = 1'b0; flush_thr = 1'b0; flush_idx = '0;
  endtask

  task automatic next_cycle();
    @(negedge clk);
    #1;
    clear_inputs();
  endtask

  task automatic do_alloc(int n, logic [AW-1:0] thr, output bit ok);
    item_t tmp[$];
    int tc[2];
    tc = tagc;
    alloc_cnt = ACW'(n);
    alloc_thr = thr;
    for (int k = 0; k < n; k++) begin
      item_t e;
      e.thr = int'(thr[k]);
      e.tag = tc[e.thr] % (1 << TW);
      e.idx = 0;
      e.seq = 0;
      alloc_tag[k] = TW'(e.tag);
      tc[e.thr]++;
      tmp.push_back(e);
    end
    #1;
    ok = alloc_ready;
    if (ok) begin
      for (int k = 0; k < n; k++) begin
        item_t e;
        e = tmp[k];
        e.idx = (int'(alloc_base) + k) % DEPTH;
        e.seq = seqn++;
        if (e.thr == 0) q0.push_back(e); else q1.push_back(e);
        pend.push_back(e);
      end
      tagc = tc;
    end
  endtask

  function automatic int find_pend(int idx);
    for (int i = 0; i < pend.size(); i++) if (pend[i].idx == idx) return i;
    return -1;
  endfunction

  task automatic wb_item(int pos, int port);
    wb_valid[port] = 1'b1;
    wb_idx[port] = IW'(pend[pos].idx);
    pend.delete(pos);
  endtask

  task automatic wb_slot(int idx, int port);
    int pos;
    pos = find_pend(idx);
    if (pos >= 0) wb_item(pos, port);
  endtask

  // Squash thread t after its branch at slot bidx (or its oldest outstanding entry if bidx < 0)
  task automatic do_flush(int t, int bidx);
    int bseq, bslot;
    bseq = -1; bslot = -1;
    if (t == 0) begin
      for (int i = 0; i < q0.size(); i++)
        if (bseq < 0 && find_pend(q0[i].idx) >= 0 && (bidx < 0 || q0[i].idx == bidx)) begin
          bseq = q0[i].seq; bslot = q0[i].idx;
        end
    end else begin
      for (int i = 0; i < q1.size(); i++)
        if (bseq < 0 && find_pend(q1[i].idx) >= 0 && (bidx < 0 || q1[i].idx == bidx)) begin
          bseq = q1[i].seq; bslot = q1[i].idx;
        end
    end
    if (bseq >= 0) begin
      flush_valid = 1'b1;
      flush_thr = t[0];
      flush_idx = IW'(bslot);
      if (t == 0) begin
        for (int i = q0.size() - 1; i >= 0; i--) if (q0[i].seq > bseq) q0.delete(i);
      end else begin
        for (int i = q1.size() - 1; i >= 0; i--) if (q1[i].seq > bseq) q1.delete(i);
      end
      for (int i = pend.size() - 1; i >= 0; i--)
        if (pend[i].thr == t && pend[i].seq > bseq) pend.delete(i);
    end
  endtask

  task automatic drain(string req);
    while (pend.size() > 0) begin
      next_cycle();
      for (int p = 0; p < WBN; p++) if (pend.size() > 0) wb_item(0, p);
    end
    repeat (60) next_cycle();
    check(q0.size() + q1.size() == 0, req, q0.size() + q1.size(), 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    bit ok;
    int base_full;
    rst_n = 1'b0;
    clear_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    next_cycle();
    alloc_cnt = 3'd4;
    #1;
    check(alloc_ready == 1'b1, "R1 ready after reset", int'(alloc_ready), 1);
    check(ret_valid == '0, "R1 no retirement after reset", int'(ret_valid), 0);
    check(alloc_base == '0, "R1 base after reset", int'(alloc_base), 0);
    alloc_cnt = '0;

    // R2, R4, R6: one thread, completion in reverse order
    next_cycle();
    check(alloc_base == '0, "R2 first base", int'(alloc_base), 0);
    do_alloc(4, 4'b0000, ok);
    next_cycle();
    check(alloc_base == IW'(4), "R2 base advanced by four", int'(alloc_base), 4);
    wb_slot(3, 0); wb_slot(2, 1); wb_slot(1, 2);
    next_cycle();
    check(ret_valid == '0, "R6 younger done, oldest pending", int'(ret_valid), 0);
    wb_slot(0, 0);
    next_cycle();
    check(ret_valid == 4'b1111, "R4 completion releases all four", int'(ret_valid), 15);

    // R7: interleaved threads, only thread 1 complete
    next_cycle();
    do_alloc(4, 4'b1010, ok);
    next_cycle();
    wb_slot(5, 0); wb_slot(7, 1);
    next_cycle();
    check(ret_valid == 4'b1010, "R7 other thread retires past stall", int'(ret_valid), 10);
    next_cycle();
    check(ret_valid == '0, "R7 stalled thread still waits", int'(ret_valid), 0);
    wb_slot(4, 0); wb_slot(6, 1);
    next_cycle();
    check(ret_valid == 4'b0101, "R6 stalled thread retires in order", int'(ret_valid), 5);

    // R8: directed flush of thread 0 at slot 9
    next_cycle();
    do_alloc(4, 4'b0000, ok);
    next_cycle();
    do_alloc(4, 4'b0110, ok);
    next_cycle();
    do_flush(0, 9);
    next_cycle();
    wb_slot(13, 0); wb_slot(14, 1); wb_slot(8, 2);
    next_cycle();
    check(ret_valid == 4'b0001, "R8 only entry older than branch", int'(ret_valid), 1);
    wb_slot(9, 0);
    next_cycle();
    check(ret_valid == 4'b0001, "R8 squashed slots do not retire", int'(ret_valid), 1);
    next_cycle();
    check(ret_valid == 4'b0011, "R8 other thread unaffected", int'(ret_valid), 3);
    repeat (4) next_cycle();

    // R3, R9: fill to capacity
    for (int g = 0; g < 31; g++) begin
      next_cycle();
      do_alloc(4, AW'($urandom), ok);
      check(ok, "R2 fill accepted", int'(ok), 1);
    end
    next_cycle();
    do_alloc(3, AW'($urandom), ok);
    next_cycle();
    alloc_cnt = 3'd4;
    #1;
    check(alloc_ready == 1'b0, "R3 four requested with one free", int'(alloc_ready), 0);
    alloc_cnt = '0;
    do_alloc(1, 4'b0001, ok);
    check(ok, "R3 one requested with one free", int'(ok), 1);
    next_cycle();
    base_full = int'(alloc_base);
    alloc_cnt = 3'd1;
    #1;
    check(alloc_ready == 1'b0, "R3 full buffer stalls", int'(alloc_ready), 0);
    next_cycle();
    check(int'(alloc_base) == base_full, "R3 no allocation while stalled", int'(alloc_base), base_full);
    drain("R9 full buffer drains");
    next_cycle();
    do_alloc(4, 4'b0101, ok);
    check(ok, "R9 slots reusable after drain", int'(ok), 1);

    // Random traffic with flushes
    for (int c = 0; c < 4000; c++) begin
      next_cycle();
      if ($urandom % 40 == 0) begin
        do_flush(int'($urandom % 2), -1);
      end else begin
        int nwb, n;
        nwb = int'($urandom % 4);
        for (int p = 0; p < nwb; p++)
          if (pend.size() > 0) wb_item(int'($urandom % pend.size()), p);
        n = int'($urandom % 5);
        if (n > 0) do_alloc(n, AW'($urandom), ok);
      end
    end
    drain("R8 random run leaves nothing outstanding");
    next_cycle();
    alloc_cnt = 3'd4;
    #1;
    check(alloc_ready == 1'b1, "R9 space after random run", int'(alloc_ready), 1);
    alloc_cnt = '0;

    summary();
    $finish;
  end
endmodule